// File: doc/BRIEF.md
# Control Endpoint Mode and Status Register with Write Lock

This block holds the eight-bit mode and status register of a USB device's control endpoint. It sits between the serial interface engine (SIE), which reports transaction events, and the CPU, which accesses the register through single-cycle read and write strobes. The SIE records the kind of the last token received and whether a transaction finished with an ACK handshake. The CPU programs the four-bit response mode and clears the status flags.

Every SIE update locks the lower seven bits against CPU writes. Only a CPU read releases that lock, so firmware must read back after each write to learn whether the write landed. The SETUP flag is protected separately. It is forced high from the start of a SETUP data packet until the start of the returned ACK packet, and the CPU cannot clear it until it has read the register after that window. While the SETUP flag is set, CPU write strobes to the endpoint FIFO are dropped, so an incoming SETUP payload cannot be overwritten before firmware reads it.

Top module: `ep0_mode_reg`

## Requirements
- R1: After reset the register reads 0x00 and the lock is released, so the first CPU write lands completely.
- R2: A token-done strobe sets one flag according to the 2-bit token code: 2'b00 (OUT) sets bit 5, 2'b01 (IN) sets bit 6 and 2'b10 (SETUP) sets bit 7. Code 2'b11 is ignored: it changes no bit and does not lock. Other bits keep their values.
- R3: An ACK-done strobe sets bit 4 and leaves all other bits unchanged.
- R4: When the register is unlocked and the SETUP flag is unprotected, a CPU write stores all eight data bits.
- R5: After any SIE update (a valid token or an ACK), CPU writes leave bits 6:0 unchanged and raise write_blocked in the cycle of the write. The lock does not cover bit 7.
- R6: A CPU read releases the lock, so the next CPU write to bits 6:0 takes effect.
- R7: When an SIE update coincides with a CPU write, the SIE result is stored, the write is discarded, write_blocked is raised and the lock is set. When an SIE update coincides with a CPU read, the lock remains set.
- R8: From the setup-data-start strobe until the ack-start strobe, bit 7 reads 1. A CPU write with bit 7 at 0 does not clear it and raises write_blocked. Bits 6:0 of that write still land if the register is unlocked. A CPU read inside this window does not end the protection.
- R9: After the ack-start strobe, bit 7 cannot be cleared by the CPU until the CPU has read the register. After that read, a write of 0 to bit 7 clears it.
- R10: While bit 7 is set, FIFO write strobes are not passed on and write_blocked is raised. While bit 7 is clear, they are passed through in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sie_tok_done | input | 1 | End of a token phase; the token code is valid |
| sie_tok_kind | input | 2 | Token code: 00 OUT, 01 IN, 10 SETUP, 11 none |
| sie_ack_done | input | 1 | Transaction completed with an ACK handshake |
| sie_setup_data | input | 1 | Start of the data packet of a SETUP transaction |
| sie_ack_start | input | 1 | Start of the ACK packet returned by the SIE |
| cpu_rd | input | 1 | CPU read strobe of the register |
| cpu_wr | input | 1 | CPU write strobe of the register |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | Current register value |
| cpu_fifo_wr | input | 1 | CPU write strobe to the endpoint FIFO |
| fifo_wr | output | 1 | FIFO write strobe after gating |
| write_blocked | output | 1 | Pulses for a CPU register or FIFO write that was fully or partly suppressed |

## Verification
On every cycle, the assertions check the following. Bit 7 stays set while the SETUP protection is active. A locked write never alters bits 6:0. An SIE update always leaves the lock set, and a read without a coinciding update always releases it. A gated FIFO write always raises write_blocked. Only the bench scenarios can show the full ordering that firmware relies on. These scenarios include sweeping every write value in the unlocked and locked states, every token code, and collisions of SIE events with CPU strobes. They also follow the window through its start, a read inside it, its end, and the release read.

// File: rtl/ep0_reg_pkg.sv
package ep0_reg_pkg;
  typedef enum logic [1:0] {
    TOK_OUT   = 2'b00,
    TOK_IN    = 2'b01,
    TOK_SETUP = 2'b10,
    TOK_NONE  = 2'b11
  } tok_kind_e;
endpackage

// File: rtl/ep0_lock_ctl.sv
module ep0_lock_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic sie_upd_i,
  input  logic cpu_rd_i,
  input  logic setup_data_i,
  input  logic ack_start_i,
  output logic lock_o,
  output logic protect_o
);
  logic lock_q, lock_n;
  logic window_q, window_n;
  logic pend_q, pend_n;

  always_comb begin
    lock_n = lock_q;
    if (sie_upd_i)     lock_n = 1'b1;   // SIE update wins over a read
    else if (cpu_rd_i) lock_n = 1'b0;

    window_n = window_q;
    if (setup_data_i)     window_n = 1'b1;
    else if (ack_start_i) window_n = 1'b0;

    pend_n = pend_q;
    if (ack_start_i && window_q)   pend_n = 1'b1;
    else if (cpu_rd_i && !window_q) pend_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q   <= 1'b0;
      window_q <= 1'b0;
      pend_q   <= 1'b0;
    end else begin
      lock_q   <= lock_n;
      window_q <= window_n;
      pend_q   <= pend_n;
    end
  end

  assign lock_o    = lock_q;
  assign protect_o = window_q | pend_q;

  // R7: any SIE update leaves the lock set
  a_r7_sie_locks: assert property (@(posedge clk) disable iff (!rst_n)
    sie_upd_i |=> lock_o);
  // R6: a read with no coinciding update releases the lock
  a_r6_read_unlocks: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rd_i && !sie_upd_i) |=> !lock_o);
endmodule

// File: rtl/ep0_status_reg.sv
module ep0_status_reg
  import ep0_reg_pkg::*;
#(
  parameter int MODE_W = 4,
  localparam int REG_W = MODE_W + 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpu_wr_i,
  input  logic [REG_W-1:0] cpu_wdata_i,
  input  logic             lock_i,
  input  logic             protect_i,
  input  logic             setup_data_i,
  input  logic             sie_upd_i,
  input  logic             tok_done_i,
  input  tok_kind_e        tok_kind_i,
  input  logic             ack_done_i,
  output logic [REG_W-1:0] q_o,
  output logic             wr_blocked_o
);
  localparam int B_SETUP = REG_W - 1;
  localparam int B_IN    = REG_W - 2;
  localparam int B_OUT   = REG_W - 3;
  localparam int B_ACK   = MODE_W;

  logic [REG_W-1:0] q_q, q_n;
  logic             load_en;

  always_comb begin
    q_n = q_q;
    if (sie_upd_i) begin
      if (tok_done_i) begin
        case (tok_kind_i)
          TOK_SETUP: q_n[B_SETUP] = 1'b1;
          TOK_IN:    q_n[B_IN]    = 1'b1;
          TOK_OUT:   q_n[B_OUT]   = 1'b1;
          default:   ;
        endcase
      end
      if (ack_done_i) q_n[B_ACK] = 1'b1;
    end else if (cpu_wr_i) begin
      if (!lock_i)    q_n[B_SETUP-1:0] = cpu_wdata_i[B_SETUP-1:0];
      if (!protect_i) q_n[B_SETUP]     = cpu_wdata_i[B_SETUP];
    end
    if (setup_data_i) q_n[B_SETUP] = 1'b1;
  end

  assign load_en = (q_n != q_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       q_q <= '0;
    else if (load_en) q_q <= q_n;
  end

  assign q_o = q_q;
  assign wr_blocked_o = cpu_wr_i &
                        (sie_upd_i | lock_i |
                         ((protect_i | setup_data_i) & ~cpu_wdata_i[B_SETUP]));

  // R5: a locked write never changes bits below the SETUP flag
  a_r5_locked_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_i && cpu_wr_i && !sie_upd_i) |=> (q_o[B_SETUP-1:0] == $past(q_o[B_SETUP-1:0])));
  // R8, R9: SETUP flag held high while protection is active
  a_r9_setup_kept: assert property (@(posedge clk) disable iff (!rst_n)
    protect_i |-> q_o[B_SETUP]);
  // R2: a SETUP token sets the SETUP flag
  a_r2_setup_token: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_done_i && tok_kind_i == TOK_SETUP) |=> q_o[B_SETUP]);
endmodule

// File: rtl/ep0_fifo_gate.sv
module ep0_fifo_gate (
  input  logic setup_flag_i,
  input  logic fifo_wr_i,
  output logic fifo_wr_o,
  output logic blocked_o
);
  assign fifo_wr_o = fifo_wr_i & ~setup_flag_i;
  assign blocked_o = fifo_wr_i &  setup_flag_i;
endmodule

// File: rtl/ep0_mode_reg.sv
module ep0_mode_reg
  import ep0_reg_pkg::*;
#(
  parameter int MODE_W = 4,
  localparam int REG_W = MODE_W + 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sie_tok_done,
  input  logic [1:0]       sie_tok_kind,
  input  logic             sie_ack_done,
  input  logic             sie_setup_data,
  input  logic             sie_ack_start,
  input  logic             cpu_rd,
  input  logic             cpu_wr,
  input  logic [REG_W-1:0] cpu_wdata,
  output logic [REG_W-1:0] cpu_rdata,
  input  logic             cpu_fifo_wr,
  output logic             fifo_wr,
  output logic             write_blocked
);
  tok_kind_e        kind;
  logic             sie_upd;
  logic             lock, protect;
  logic [REG_W-1:0] q;
  logic             reg_blk, fifo_blk;

  assign kind    = tok_kind_e'(sie_tok_kind);
  assign sie_upd = (sie_tok_done && kind != TOK_NONE) || sie_ack_done;

  ep0_lock_ctl u_lock (
    .clk          (clk),
    .rst_n        (rst_n),
    .sie_upd_i    (sie_upd),
    .cpu_rd_i     (cpu_rd),
    .setup_data_i (sie_setup_data),
    .ack_start_i  (sie_ack_start),
    .lock_o       (lock),
    .protect_o    (protect)
  );

  ep0_status_reg #(.MODE_W(MODE_W)) u_stat (
    .clk          (clk),
    .rst_n        (rst_n),
    .cpu_wr_i     (cpu_wr),
    .cpu_wdata_i  (cpu_wdata),
    .lock_i       (lock),
    .protect_i    (protect),
    .setup_data_i (sie_setup_data),
    .sie_upd_i    (sie_upd),
    .tok_done_i   (sie_tok_done),
    .tok_kind_i   (kind),
    .ack_done_i   (sie_ack_done),
    .q_o          (q),
    .wr_blocked_o (reg_blk)
  );

  ep0_fifo_gate u_gate (
    .setup_flag_i (q[REG_W-1]),
    .fifo_wr_i    (cpu_fifo_wr),
    .fifo_wr_o    (fifo_wr),
    .blocked_o    (fifo_blk)
  );

  assign cpu_rdata     = q;
  assign write_blocked = reg_blk | fifo_blk;

  // R10: a FIFO strobe under a set SETUP flag is reported as blocked
  a_r10_fifo_report: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_fifo_wr && cpu_rdata[REG_W-1]) |-> (write_blocked && !fifo_wr));
endmodule

// File: tb/ep0_mode_reg_tb.sv
module ep0_mode_reg_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tok_done = 1'b0, ack_done = 1'b0, setup_data = 1'b0, ack_start = 1'b0;
  logic [1:0] tok_kind = 2'b11;
  logic rd = 1'b0, wr = 1'b0, fwr = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic fifo_wr, wblk;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ep0_mode_reg u_dut (
    .clk(clk), .rst_n(rst_n),
    .sie_tok_done(tok_done), .sie_tok_kind(tok_kind), .sie_ack_done(ack_done),
    .sie_setup_data(setup_data), .sie_ack_start(ack_start),
    .cpu_rd(rd), .cpu_wr(wr), .cpu_wdata(wdata), .cpu_rdata(rdata),
    .cpu_fifo_wr(fwr), .fifo_wr(fifo_wr), .write_blocked(wblk)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
    tok_done = 0; ack_done = 0; setup_data = 0; ack_start = 0;
    rd = 0; wr = 0; fwr = 0;
  endtask

  task automatic do_wr(input logic [7:0] v, input string tag, input bit exp_blk);
    wr = 1; wdata = v; #1;
    chk({tag, " write_blocked"}, wblk, exp_blk);
    tick();
  endtask

  task automatic do_rd();
    rd = 1; tick();
  endtask

  task automatic do_tok(input logic [1:0] k);
    tok_done = 1; tok_kind = k; tick();
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] e;
    #9; rst_n = 1; #2;
    @(posedge clk); #1;
    chk("R1 reset value", rdata, 8'h00);
    do_wr(8'h5A, "R1", 0);
    chk("R1 first write lands", rdata, 8'h5A);

    // R4: unlocked sweep over every value
    for (int v = 0; v < 256; v++) begin
      do_wr(8'(v), "R4", 0);
      chk("R4 unlocked store", rdata, v);
    end

    // R2: every token code
    for (int k = 0; k < 4; k++) begin
      do_rd();
      do_wr(8'h00, "R2 clear", 0);
      do_tok(2'(k));
      e = (k == 0) ? 8'h20 : (k == 1) ? 8'h40 : (k == 2) ? 8'h80 : 8'h00;
      chk("R2 token flag", rdata, e);
      if (k == 3) begin
        do_wr(8'h03, "R2 ignored code no lock", 0);
        chk("R2 ignored code no lock", rdata, 8'h03);
      end else begin
        do_wr(8'h03, "R5 locked after token", 1);
        chk("R5 locked after token", rdata, e & 8'h7F);
      end
    end

    // R5: locked sweep
    do_rd();
    do_wr(8'h00, "R5 clear", 0);
    do_tok(2'b01);
    for (int v = 0; v < 256; v++) begin
      do_wr(8'(v), "R5", 1);
      chk("R5 locked bits", rdata, {v[7], 7'h40});
    end

    // R6: read releases lock
    do_rd();
    do_wr(8'h02, "R6", 0);
    chk("R6 write after read", rdata, 8'h02);

    // R3: ACK sets bit 4
    ack_done = 1; tick();
    chk("R3 ack flag", rdata, 8'h12);
    do_wr(8'h00, "R3 locks", 1);
    chk("R3 ack locks", rdata, 8'h12);

    // R7: collisions
    do_rd();
    do_wr(8'h00, "R7 clear", 0);
    tok_done = 1; tok_kind = 2'b01; wr = 1; wdata = 8'h0F; #1;
    chk("R7 collision write_blocked", wblk, 1);
    tick();
    chk("R7 SIE wins", rdata, 8'h40);
    do_wr(8'h0F, "R7 lock set", 1);
    chk("R7 lock set", rdata, 8'h40);
    rd = 1; ack_done = 1; tick();
    chk("R7 read+ack", rdata, 8'h50);
    do_wr(8'h00, "R7 lock kept", 1);
    chk("R7 lock kept", rdata, 8'h50);

    // R8: SETUP window
    do_rd();
    do_wr(8'h00, "R8 clear", 0);
    setup_data = 1; tick();
    chk("R8 forced high", rdata, 8'h80);
    do_wr(8'h05, "R8 window", 1);
    chk("R8 bit7 held", rdata, 8'h85);
    do_rd();
    ack_start = 1; tick();
    do_wr(8'h00, "R8 read in window ignored", 1);
    chk("R8 read in window ignored", rdata, 8'h80);

    // R9 / R10 after the window
    fwr = 1; #1;
    chk("R10 fifo gated", fifo_wr, 0);
    chk("R10 fifo blocked", wblk, 1);
    tick();
    do_rd();
    do_wr(8'h00, "R9 release", 0);
    chk("R9 cleared after read", rdata, 8'h00);
    fwr = 1; #1;
    chk("R10 fifo passes", fifo_wr, 1);
    chk("R10 fifo not blocked", wblk, 0);
    tick();

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule